// File: doc/BRIEF.md
# Five-Input Priority Interrupt Controller

This block collects five interrupt request lines for a small processor core. It picks one request by fixed priority and presents it to the core as a request flag and a 16-bit service address. When the core takes the interrupt, it pulses the acknowledge input. The acknowledge retires the chosen request where that request is latched, and it closes the global enable.

The top line is non-maskable and ignores all gating. The next three lines each have their own mask bit. The highest of those three is captured on a rising edge and held until it is serviced. The lowest-ranked line is a general request. Its service address comes from a 3-bit restart number that the requesting device supplies.

The core controls the block through an enable command, a disable command and a set-mask write. A read-mask word returns the masks, the enable state, the pending status of the three masked lines and a serial input bit. The set-mask write can also update a serial output bit.

Top module: `prio_irq_ctrl`

## Requirements
- R1: The ranking, highest first, is nmi_i, irq_edge_i, irq_mid_i, irq_low_i, irq_gen_i. With several lines eligible at once, vec_o and the acknowledge action belong to the highest-ranked one.
- R2: The fixed service addresses are 0x0024 for nmi_i, 0x003C for irq_edge_i, 0x0034 for irq_mid_i and 0x002C for irq_low_i.
- R3: When irq_gen_i is granted, vec_o equals rst_num_i multiplied by 8, giving 0x0000 to 0x0038.
- R4: The enable flag behaves as follows.
  - Reset clears it, ie_set_i sets it and ie_clr_i clears it.
  - An acknowledge of any grant (ack_i with irq_o high) clears it, and this overrides ie_set_i.
  - While the flag is clear, only the non-maskable line can raise irq_o.
- R5: nmi_i is gated by neither the enable flag nor the masks. It becomes pending only after a rising edge, and it stays pending only while the input stays high. Its acknowledge retires it until the next rising edge.
- R6: The mask bits work as follows. Mask bits are 1 after reset, and a mask bit of 1 blocks its line. A set-mask write copies mask_wdata_i[2:0] into the masks only when mask_wdata_i[3] is 1. Bit 0 is irq_low_i, bit 1 is irq_mid_i and bit 2 is irq_edge_i.
- R7: A rising edge on irq_edge_i sets a latch that holds after the input falls. The latch is cleared by an acknowledge that grants this line, or by a set-mask write with bit 4 set. A new edge in the same cycle as a clear wins.
- R8: mask_rdata_o is arranged as follows.
  - Bits 2:0 are the masks for low, mid and edge.
  - Bit 3 is the enable flag.
  - Bit 4 is the irq_low_i level, bit 5 is the irq_mid_i level and bit 6 is the edge latch.
  - Bit 7 is ser_in_i.
- R9: A set-mask write with bit 6 set loads bit 7 into ser_out_o. Otherwise ser_out_o holds, and reset clears it.
- R10: irq_mid_i, irq_low_i and irq_gen_i are level lines. Dropping the input removes the request with nothing left pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nmi_i | input | 1 | Non-maskable request, qualified by edge and level |
| irq_edge_i | input | 1 | Maskable request captured on a rising edge |
| irq_mid_i | input | 1 | Maskable level request |
| irq_low_i | input | 1 | Maskable level request |
| irq_gen_i | input | 1 | General level request |
| rst_num_i | input | 3 | Restart number for the general request |
| ie_set_i | input | 1 | Enable command |
| ie_clr_i | input | 1 | Disable command |
| mask_wr_i | input | 1 | Set-mask write strobe |
| mask_wdata_i | input | 8 | Set-mask write word |
| mask_rdata_o | output | 8 | Read-mask status word |
| ser_in_i | input | 1 | Serial input bit |
| ser_out_o | output | 1 | Serial output bit |
| irq_o | output | 1 | Request to core |
| vec_o | output | 16 | Service address of the granted request |
| ack_i | input | 1 | Core acknowledge |

## Verification
The hardest case to reach is a rearm-free non-maskable line. After the acknowledge has retired it, nmi_i can still be high with no new edge, and it must then request nothing. The stimulus keeps nmi_i high through the acknowledge and checks that irq_o stays low with the enable flag already cleared. It then drops nmi_i and raises it again to confirm that only a fresh edge rearms the line. The edge latch of irq_edge_i needs a similar sequence. The input falls before service, and the latch is then retired by a set-mask write instead of by an acknowledge.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int unsigned NUM_SRC = 5;
  localparam int unsigned VEC_W   = 16;
  localparam int unsigned RN_W    = 3;
  localparam int unsigned MASK_W  = 3;

  typedef enum logic [2:0] {
    SRC_NMI  = 3'd0,
    SRC_EDGE = 3'd1,
    SRC_MID  = 3'd2,
    SRC_LOW  = 3'd3,
    SRC_GEN  = 3'd4,
    SRC_NONE = 3'd7
  } src_e;

  localparam logic [VEC_W-1:0] VEC_NMI  = 16'h0024;
  localparam logic [VEC_W-1:0] VEC_EDGE = 16'h003C;
  localparam logic [VEC_W-1:0] VEC_MID  = 16'h0034;
  localparam logic [VEC_W-1:0] VEC_LOW  = 16'h002C;

  // set-mask word fields
  localparam int unsigned WB_APPLY = 3;
  localparam int unsigned WB_ECLR  = 4;
  localparam int unsigned WB_SEN   = 6;
  localparam int unsigned WB_SDAT  = 7;
endpackage

// File: rtl/irq_capture.sv
module irq_capture (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_i,
  input  logic edge_i,
  input  logic nmi_ack_i,
  input  logic edge_ack_i,
  input  logic edge_clr_i,
  output logic nmi_pend_o,
  output logic edge_lat_o
);
  logic nmi_q, edge_q, nmi_lat_q, edge_lat_q;
  logic nmi_rise, edge_rise;

  assign nmi_rise  = nmi_i & ~nmi_q;
  assign edge_rise = edge_i & ~edge_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_q      <= 1'b0;
      edge_q     <= 1'b0;
      nmi_lat_q  <= 1'b0;
      edge_lat_q <= 1'b0;
    end else begin
      nmi_q  <= nmi_i;
      edge_q <= edge_i;
      if (nmi_rise)                  nmi_lat_q <= 1'b1;
      else if (nmi_ack_i || !nmi_i)  nmi_lat_q <= 1'b0;
      // new edge beats a same-cycle clear
      if (edge_rise)                      edge_lat_q <= 1'b1;
      else if (edge_ack_i || edge_clr_i)  edge_lat_q <= 1'b0;
    end
  end

  assign nmi_pend_o = nmi_lat_q & nmi_i;
  assign edge_lat_o = edge_lat_q;
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import prio_irq_pkg::*;
#(
  parameter int unsigned MW = MASK_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ie_set_i,
  input  logic          ie_clr_i,
  input  logic          ack_i,
  input  logic          wr_i,
  input  logic [7:0]    wdata_i,
  output logic          ie_o,
  output logic [MW-1:0] mask_o,
  output logic          ser_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_o   <= 1'b0;
      mask_o <= '1;
      ser_o  <= 1'b0;
    end else begin
      if (ack_i)         ie_o <= 1'b0;
      else if (ie_clr_i) ie_o <= 1'b0;
      else if (ie_set_i) ie_o <= 1'b1;
      if (wr_i && wdata_i[WB_APPLY]) mask_o <= wdata_i[MW-1:0];
      if (wr_i && wdata_i[WB_SEN])   ser_o  <= wdata_i[WB_SDAT];
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import prio_irq_pkg::*;
#(
  parameter int unsigned NS = NUM_SRC,
  parameter int unsigned VW = VEC_W,
  parameter int unsigned RW = RN_W
) (
  input  logic [NS-1:0] req_i,
  input  logic [RW-1:0] rst_num_i,
  output logic          valid_o,
  output src_e          sel_o,
  output logic [VW-1:0] vec_o
);
  localparam int unsigned PADW = VW - RW - 3;

  always_comb begin
    sel_o = SRC_NONE;
    for (int i = NS - 1; i >= 0; i--) begin
      if (req_i[i]) sel_o = src_e'(3'(i));
    end
  end

  assign valid_o = |req_i;

  always_comb begin
    unique case (sel_o)
      SRC_NMI:  vec_o = VEC_NMI;
      SRC_EDGE: vec_o = VEC_EDGE;
      SRC_MID:  vec_o = VEC_MID;
      SRC_LOW:  vec_o = VEC_LOW;
      SRC_GEN:  vec_o = {{PADW{1'b0}}, rst_num_i, 3'b000};
      default:  vec_o = '0;
    endcase
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        nmi_i,
  input  logic        irq_edge_i,
  input  logic        irq_mid_i,
  input  logic        irq_low_i,
  input  logic        irq_gen_i,
  input  logic [2:0]  rst_num_i,
  input  logic        ie_set_i,
  input  logic        ie_clr_i,
  input  logic        mask_wr_i,
  input  logic [7:0]  mask_wdata_i,
  output logic [7:0]  mask_rdata_o,
  input  logic        ser_in_i,
  output logic        ser_out_o,
  output logic        irq_o,
  output logic [15:0] vec_o,
  input  logic        ack_i
);
  logic              nmi_pend, edge_lat, ie;
  logic [MASK_W-1:0] mask;
  logic [NUM_SRC-1:0] req;
  logic              ack_fire;
  src_e              sel;

  assign ack_fire = ack_i & irq_o;

  irq_capture u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .nmi_i      (nmi_i),
    .edge_i     (irq_edge_i),
    .nmi_ack_i  (ack_fire && sel == SRC_NMI),
    .edge_ack_i (ack_fire && sel == SRC_EDGE),
    .edge_clr_i (mask_wr_i && mask_wdata_i[WB_ECLR]),
    .nmi_pend_o (nmi_pend),
    .edge_lat_o (edge_lat)
  );

  irq_ctrl_regs #(.MW(MASK_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ie_set_i (ie_set_i),
    .ie_clr_i (ie_clr_i),
    .ack_i    (ack_fire),
    .wr_i     (mask_wr_i),
    .wdata_i  (mask_wdata_i),
    .ie_o     (ie),
    .mask_o   (mask),
    .ser_o    (ser_out_o)
  );

  assign req[SRC_NMI]  = nmi_pend;
  assign req[SRC_EDGE] = ie & edge_lat  & ~mask[2];
  assign req[SRC_MID]  = ie & irq_mid_i & ~mask[1];
  assign req[SRC_LOW]  = ie & irq_low_i & ~mask[0];
  assign req[SRC_GEN]  = ie & irq_gen_i;

  irq_arbiter #(.NS(NUM_SRC), .VW(VEC_W), .RW(RN_W)) u_arb (
    .req_i     (req),
    .rst_num_i (rst_num_i),
    .valid_o   (irq_o),
    .sel_o     (sel),
    .vec_o     (vec_o)
  );

  assign mask_rdata_o = {ser_in_i, edge_lat, irq_mid_i, irq_low_i, ie, mask};
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        irq_edge_i,
  input logic        ie_set_i,
  input logic        mask_wr_i,
  input logic [7:0]  mask_wdata_i,
  input logic [7:0]  mask_rdata_o,
  input logic        ser_out_o,
  input logic        irq_o,
  input logic [15:0] vec_o,
  input logic        ack_i
);
  // R2
  fixed_vec_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (vec_o == 16'h0024 || vec_o == 16'h003C || vec_o == 16'h0034 ||
               vec_o == 16'h002C || (vec_o[15:6] == '0 && vec_o[2:0] == '0)));
  // R4
  ack_closes_ie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o) |=> !mask_rdata_o[3]);
  // R5
  disabled_only_nmi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !mask_rdata_o[3]) |-> vec_o == 16'h0024);
  // R6
  mask_apply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_wr_i && mask_wdata_i[3]) |=> mask_rdata_o[2:0] == $past(mask_wdata_i[2:0]));
  // R9
  ser_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_wr_i && mask_wdata_i[6]) |=> ser_out_o == $past(mask_wdata_i[7]));
  // R9
  ser_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mask_wr_i && mask_wdata_i[6]) |=> $stable(ser_out_o));
  // R7
  edge_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_edge_i && !$past(irq_edge_i)) |=> mask_rdata_o[6]);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .irq_edge_i   (irq_edge_i),
  .ie_set_i     (ie_set_i),
  .mask_wr_i    (mask_wr_i),
  .mask_wdata_i (mask_wdata_i),
  .mask_rdata_o (mask_rdata_o),
  .ser_out_o    (ser_out_o),
  .irq_o        (irq_o),
  .vec_o        (vec_o),
  .ack_i        (ack_i)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic nmi = 0, e_in = 0, mid = 0, low = 0, gen = 0;
  logic [2:0] rn = '0;
  logic ie_set = 0, ie_clr = 0, mwr = 0, sin = 0, ack = 0;
  logic [7:0] mwd = '0;
  logic [7:0] rdata;
  logic sout, irq;
  logic [15:0] vec;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .nmi_i(nmi), .irq_edge_i(e_in), .irq_mid_i(mid),
    .irq_low_i(low), .irq_gen_i(gen), .rst_num_i(rn), .ie_set_i(ie_set),
    .ie_clr_i(ie_clr), .mask_wr_i(mwr), .mask_wdata_i(mwd), .mask_rdata_o(rdata),
    .ser_in_i(sin), .ser_out_o(sout), .irq_o(irq), .vec_o(vec), .ack_i(ack)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr_mask(input logic [7:0] w);
    mwr = 1; mwd = w; tick(); mwr = 0; mwd = '0;
  endtask

  task automatic pulse_ie(input logic on);
    if (on) ie_set = 1; else ie_clr = 1;
    tick(); ie_set = 0; ie_clr = 0;
  endtask

  task automatic pulse_ack();
    ack = 1; tick(); ack = 0;
  endtask

  task automatic t_reset();
    chk("R8 reset word", 16'(rdata), 16'h0007);
    chk("R4 reset irq", 16'(irq), 16'h0);
    chk("R9 reset ser", 16'(sout), 16'h0);
    sin = 1; #1 chk("R8 ser_in bit7", 16'(rdata), 16'h0087); sin = 0;
  endtask

  task automatic t_ie();
    pulse_ie(1); chk("R4 enable set", 16'(rdata[3]), 16'h1);
    pulse_ie(0); chk("R4 disable", 16'(rdata[3]), 16'h0);
    gen = 1; rn = 3'd2; tick();
    chk("R4 gen blocked when disabled", 16'(irq), 16'h0);
    gen = 0; tick();
  endtask

  task automatic t_priority();
    wr_mask(8'h08); pulse_ie(1);
    chk("R6 unmask applied", 16'(rdata[2:0]), 16'h0);
    gen = 1; rn = 3'd5; mid = 1; low = 1; e_in = 1; tick();
    chk("R1 edge wins", vec, 16'h003C);
    chk("R8 pending bits", 16'(rdata[6:4]), 16'h7);
    pulse_ack();
    chk("R4 ack clears ie", 16'(rdata[3]), 16'h0);
    chk("R7 ack clears edge latch", 16'(rdata[6]), 16'h0);
    chk("R4 no irq after ack", 16'(irq), 16'h0);
    pulse_ie(1);
    chk("R1 mid next", vec, 16'h0034);
    mid = 0; tick();
    chk("R10 low after mid drops", vec, 16'h002C);
    low = 0; tick();
    chk("R3 gen n=5", vec, 16'h0028);
    nmi = 1; tick();
    chk("R1 nmi over all", vec, 16'h0024);
    nmi = 0; gen = 0; e_in = 0; tick();
    chk("R10 all dropped", 16'(irq), 16'h0);
  endtask

  task automatic t_gen_range();
    gen = 1; rn = 3'd0; tick();
    chk("R3 n=0 irq", 16'(irq), 16'h1);
    chk("R3 n=0 vec", vec, 16'h0000);
    rn = 3'd7; tick();
    chk("R3 n=7 vec", vec, 16'h0038);
    gen = 0; tick();
  endtask

  task automatic t_masks();
    wr_mask(8'h0F);
    mid = 1; low = 1; tick();
    chk("R6 all masked", 16'(irq), 16'h0);
    chk("R8 levels visible", 16'(rdata[5:4]), 16'h3);
    wr_mask(8'h07);
    chk("R6 no apply keeps masks", 16'(rdata[2:0]), 16'h7);
    chk("R6 no apply no irq", 16'(irq), 16'h0);
    wr_mask(8'h0D);
    chk("R6 mid unmasked", vec, 16'h0034);
    chk("R2 mid irq", 16'(irq), 16'h1);
    mid = 0; low = 0; tick();
  endtask

  task automatic t_edge_clear();
    e_in = 1; tick(); e_in = 0; tick();
    chk("R7 latch holds", 16'(rdata[6]), 16'h1);
    chk("R7 masked edge no irq", 16'(irq), 16'h0);
    wr_mask(8'h10);
    chk("R7 bit4 clears", 16'(rdata[6]), 16'h0);
    e_in = 1; mwr = 1; mwd = 8'h10; tick(); mwr = 0; mwd = '0;
    chk("R7 edge beats clear", 16'(rdata[6]), 16'h1);
    e_in = 0; wr_mask(8'h10);
  endtask

  task automatic t_serial();
    wr_mask(8'hC0); chk("R9 ser set", 16'(sout), 16'h1);
    wr_mask(8'h80); chk("R9 ser hold", 16'(sout), 16'h1);
    wr_mask(8'h40); chk("R9 ser clear", 16'(sout), 16'h0);
  endtask

  task automatic t_nmi();
    pulse_ie(0);
    wr_mask(8'h0F);
    nmi = 1; tick();
    chk("R5 nmi ignores ie/mask", 16'(irq), 16'h1);
    chk("R5 nmi vec", vec, 16'h0024);
    nmi = 0; #1 chk("R5 level drop", 16'(irq), 16'h0);
    tick(); nmi = 1; tick();
    chk("R5 rearm on edge", 16'(irq), 16'h1);
    pulse_ack();
    chk("R5 retired while high", 16'(irq), 16'h0);
    tick(); chk("R5 stays retired", 16'(irq), 16'h0);
    nmi = 0; tick(); nmi = 1; tick();
    chk("R5 fresh edge", vec, 16'h0024);
    nmi = 0; tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; tick();
    t_reset();
    t_ie();
    t_priority();
    t_gen_range();
    t_masks();
    t_edge_clear();
    t_serial();
    t_nmi();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule